// File: doc/BRIEF.md
# Multi-Mode Timer/Counter With Auto-Reload

This block is an 8+8 bit timer/counter. Its count lives in two bytes, a low byte and a high byte. A single byte-wide write port loads either byte or a small control field. The control field sets four things: a run enable for the main counter, a choice between internal and external clocking, a 2-bit counting mode, and a run enable for the high byte when it counts on its own. In internal mode the counter advances once every twelve system clocks. In external mode it advances once for each falling transition on an external pin. The pin is sampled on the same divided tick, so the fastest pin that can be counted is well below the system clock.

The four modes use the two bytes differently. Mode 0 is a 13-bit counter. Mode 1 is a 16-bit counter. Mode 2 is an 8-bit counter that reloads itself from the high byte. Mode 3 splits the bytes into two independent 8-bit counters, each with its own overflow flag. Software sets the interval by preloading the counter, so overflow arrives after fewer counts. Each overflow flag is sticky and stays set until an acknowledge pulse clears it.

Top module: `ctr_timer`

## Requirements
- R1: With run set (control bit 0 = 1) and internal clocking selected (control bit 1 = 0), the active count advances by exactly one every 12 system clock cycles and holds steady in between.
- R2: With external clocking selected (control bit 1 = 1), the low counter advances once for each 1-to-0 change of the external pin seen between two successive divided-clock samples. A pin that holds steady produces no count.
- R3: With run cleared (control bit 0 = 0), the counter bytes keep their value, although bus writes still load them.
- R4: Mode 0 (control bits 3:2 = 0) counts over 13 bits. The high byte supplies the upper 8 bits and low-byte bits 4:0 supply the lower 5 bits. Low-byte bits 7:5 never change by counting. When the count steps from all ones, it wraps to zero and sets the overflow flag.
- R5: Mode 1 (control bits 3:2 = 1) counts the full 16 bits, with the high byte as the upper half. A step from 0xFFFF gives 0x0000 and sets the overflow flag.
- R6: Mode 2 (control bits 3:2 = 2) counts in the low byte only. A step from 0xFF loads the low byte with the high-byte value, sets the overflow flag, and leaves the high byte unchanged.
- R7: Mode 3 (control bits 3:2 = 3) splits the bytes into two 8-bit counters. The low byte follows the selected clock and sets ovf_o when it wraps. The high byte always counts the internal divided clock while control bit 4 = 1, and sets ovf_hi_o when it wraps from 0xFF to 0x00.
- R8: Each overflow flag stays set until its acknowledge input is high for one cycle, which clears it. A new overflow in the same cycle as an acknowledge wins.
- R9: wr_sel_i selects the target of a write: 0 is the low byte, 1 is the high byte, 2 is the control field (bits 4:0). A write to a counter byte replaces its value and blocks counting in that cycle.
- R10: After reset, both bytes, both flags and the control field are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 low byte, 1 high byte, 2 control |
| wr_data_i | input | 8 | Write data |
| ext_pin_i | input | 1 | External count source |
| ack_ovf_i | input | 1 | Clears ovf_o |
| ack_ovf_hi_i | input | 1 | Clears ovf_hi_o |
| cnt_lo_o | output | 8 | Low byte of the count |
| cnt_hi_o | output | 8 | High byte of the count |
| ovf_o | output | 1 | Main overflow flag |
| ovf_hi_o | output | 1 | High-byte overflow flag in split mode |

## Verification
Internal state shows at the byte outputs almost at once. A wrong carry, reload path or mode decode shows at the first divided tick after the state goes wrong, which is at most twelve cycles later, because every step of the count can be seen directly. The bench follows each tick and compares it with an arithmetic model of all four modes. It preloads values close to each wrap point, so a wrong flag or wrap value shows up within a few ticks. A prescaler that is off by a cycle shows as a byte that changes early or late inside the twelve-cycle window.

// File: rtl/ctr_timer_pkg.sv
package ctr_timer_pkg;
  typedef enum logic [1:0] {
    MODE_13B    = 2'd0,
    MODE_16B    = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } ctr_mode_e;

  // packed MSB first: run_hi bit4, mode bits3:2, ext_sel bit1, run bit0
  typedef struct packed {
    logic      run_hi;
    ctr_mode_e mode;
    logic      ext_sel;
    logic      run;
  } ctr_ctrl_t;

  localparam int unsigned CTRL_W   = 5;
  localparam logic [1:0]  SEL_LO   = 2'd0;
  localparam logic [1:0]  SEL_HI   = 2'd1;
  localparam logic [1:0]  SEL_CTRL = 2'd2;
endpackage

// File: rtl/ctr_prescale.sv
module ctr_prescale #(
  parameter int unsigned DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + PW'(1);
  end

  assign tick_o = (cnt_q == LAST);

  // tick is a single-cycle pulse
  assert_tick_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/ctr_edge_sense.sv
module ctr_edge_sense #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   samp_q;
  logic                   pin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     samp_q <= 1'b0;
    else if (tick_i) samp_q <= pin_s;
  end

  // one event per 1->0 change between successive tick samples
  assign fall_o = tick_i & samp_q & ~pin_s;
endmodule

// File: rtl/ctr_count_core.sv
module ctr_count_core
  import ctr_timer_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned LOW13_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctr_mode_e         mode_i,
  input  logic              en_lo_i,
  input  logic              en_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              ack_lo_i,
  input  logic              ack_hi_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_lo_o,
  output logic              ovf_hi_o
);
  localparam int unsigned W16 = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
  logic              ovf_lo_q, ovf_hi_q;
  logic              wrap_lo, wrap_hi;
  logic [LOW13_W:0]  s13;
  logic [W16:0]      s16;
  logic [BYTE_W:0]   slo, shi;

  assign s13 = {1'b0, lo_q[LOW13_W-1:0]} + (LOW13_W+1)'(1);
  assign s16 = {1'b0, hi_q, lo_q} + (W16+1)'(1);
  assign slo = {1'b0, lo_q} + (BYTE_W+1)'(1);
  assign shi = {1'b0, hi_q} + (BYTE_W+1)'(1);

  always_comb begin
    lo_n    = lo_q;
    hi_n    = hi_q;
    wrap_lo = 1'b0;
    wrap_hi = 1'b0;
    if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) lo_n = wr_data_i;
      if (wr_hi_i) hi_n = wr_data_i;
    end else begin
      unique case (mode_i)
        MODE_13B: if (en_lo_i) begin
          lo_n[LOW13_W-1:0] = s13[LOW13_W-1:0];
          if (s13[LOW13_W]) begin
            hi_n    = shi[BYTE_W-1:0];
            wrap_lo = shi[BYTE_W];
          end
        end
        MODE_16B: if (en_lo_i) begin
          {hi_n, lo_n} = s16[W16-1:0];
          wrap_lo      = s16[W16];
        end
        MODE_RELOAD: if (en_lo_i) begin
          if (slo[BYTE_W]) begin
            lo_n    = hi_q;
            wrap_lo = 1'b1;
          end else begin
            lo_n = slo[BYTE_W-1:0];
          end
        end
        MODE_SPLIT: begin
          if (en_lo_i) begin
            lo_n    = slo[BYTE_W-1:0];
            wrap_lo = slo[BYTE_W];
          end
          if (en_hi_i) begin
            hi_n    = shi[BYTE_W-1:0];
            wrap_hi = shi[BYTE_W];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      hi_q     <= '0;
      ovf_lo_q <= 1'b0;
      ovf_hi_q <= 1'b0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
      if (wrap_lo)       ovf_lo_q <= 1'b1;
      else if (ack_lo_i) ovf_lo_q <= 1'b0;
      if (wrap_hi)       ovf_hi_q <= 1'b1;
      else if (ack_hi_i) ovf_hi_q <= 1'b0;
    end
  end

  assign lo_o     = lo_q;
  assign hi_o     = hi_q;
  assign ovf_lo_o = ovf_lo_q;
  assign ovf_hi_o = ovf_hi_q;

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_lo_i && !en_hi_i && !wr_lo_i && !wr_hi_i |=> lo_q == $past(lo_q) && hi_q == $past(hi_q));

  assert_m13_upper_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_13B && !wr_lo_i |=> lo_q[BYTE_W-1:LOW13_W] == $past(lo_q[BYTE_W-1:LOW13_W]));

  assert_m16_wrap_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_16B && en_lo_i && !wr_lo_i && !wr_hi_i && (&{hi_q, lo_q})
    |=> hi_q == '0 && lo_q == '0 && ovf_lo_q);

  assert_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_RELOAD && en_lo_i && !wr_lo_i && !wr_hi_i && (&lo_q)
    |=> lo_q == $past(hi_q) && hi_q == $past(hi_q) && ovf_lo_q);

  assert_split_hi_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_SPLIT && !en_hi_i && !wr_hi_i |=> hi_q == $past(hi_q));

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_lo_q && !ack_lo_i |=> ovf_lo_q);

  assert_ack_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_hi_i && !en_hi_i |=> !ovf_hi_q);
endmodule

// File: rtl/ctr_timer.sv
module ctr_timer
  import ctr_timer_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned DIV         = 12,
  parameter int unsigned LOW13_W     = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              ext_pin_i,
  input  logic              ack_ovf_i,
  input  logic              ack_ovf_hi_i,
  output logic [BYTE_W-1:0] cnt_lo_o,
  output logic [BYTE_W-1:0] cnt_hi_o,
  output logic              ovf_o,
  output logic              ovf_hi_o
);
  ctr_ctrl_t ctrl_q;
  logic      tick, fall, en_lo, en_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              ctrl_q <= '0;
    else if (wr_en_i && wr_sel_i == SEL_CTRL) ctrl_q <= ctr_ctrl_t'(wr_data_i[CTRL_W-1:0]);
  end

  ctr_prescale #(.DIV(DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  ctr_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .pin_i (ext_pin_i),
    .fall_o(fall)
  );

  assign en_lo = ctrl_q.run & (ctrl_q.ext_sel ? fall : tick);
  assign en_hi = ctrl_q.run_hi & tick & (ctrl_q.mode == MODE_SPLIT);

  ctr_count_core #(.BYTE_W(BYTE_W), .LOW13_W(LOW13_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (ctrl_q.mode),
    .en_lo_i  (en_lo),
    .en_hi_i  (en_hi),
    .wr_lo_i  (wr_en_i && wr_sel_i == SEL_LO),
    .wr_hi_i  (wr_en_i && wr_sel_i == SEL_HI),
    .wr_data_i(wr_data_i),
    .ack_lo_i (ack_ovf_i),
    .ack_hi_i (ack_ovf_hi_i),
    .lo_o     (cnt_lo_o),
    .hi_o     (cnt_hi_o),
    .ovf_lo_o (ovf_o),
    .ovf_hi_o (ovf_hi_o)
  );

  // external fall events only arrive on a divided tick
  assert_ext_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.run && ctrl_q.ext_sel && !tick && !wr_en_i |=> $stable(cnt_lo_o));
endmodule

// File: tb/ctr_timer_tb_top.sv
module ctr_timer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd0;
  logic [7:0] wr_data_i = 8'd0;
  logic       ext_pin_i = 1'b0;
  logic       ack_ovf_i = 1'b0;
  logic       ack_ovf_hi_i = 1'b0;
  logic [7:0] cnt_lo_o, cnt_hi_o;
  logic       ovf_o, ovf_hi_o;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  always #2 clk_i = ~clk_i;

  ctr_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .ext_pin_i(ext_pin_i), .ack_ovf_i(ack_ovf_i),
    .ack_ovf_hi_i(ack_ovf_hi_i), .cnt_lo_o(cnt_lo_o), .cnt_hi_o(cnt_hi_o),
    .ovf_o(ovf_o), .ovf_hi_o(ovf_hi_o)
  );

  function automatic logic [17:0] obs();
    return {ovf_hi_o, ovf_o, cnt_hi_o, cnt_lo_o};
  endfunction

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // arithmetic model of one count step: {ovf_hi, ovf, hi, lo}
  function automatic logic [17:0] model(input logic [1:0] m, input logic [7:0] h,
                                        input logic [7:0] l, input bit le, input bit he);
    int v;
    logic oh = 1'b0, ol = 1'b0;
    case (m)
      2'd0: if (le) begin
        v = h * 32 + (l % 32) + 1;
        if (v == 8192) begin v = 0; ol = 1'b1; end
        h = 8'(v / 32);
        l = 8'((l / 32) * 32 + v % 32);
      end
      2'd1: if (le) begin
        v = h * 256 + l + 1;
        if (v == 65536) begin v = 0; ol = 1'b1; end
        h = 8'(v / 256);
        l = 8'(v % 256);
      end
      2'd2: if (le) begin
        if (l == 8'hFF) begin l = h; ol = 1'b1; end
        else l = l + 8'd1;
      end
      default: begin
        if (le) begin ol = (l == 8'hFF); l = l + 8'd1; end
        if (he) begin oh = (h == 8'hFF); h = h + 8'd1; end
      end
    endcase
    return {oh, ol, h, l};
  endfunction

  task automatic bus_wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic ack_both();
    @(negedge clk_i);
    ack_ovf_i = 1'b1; ack_ovf_hi_i = 1'b1;
    @(negedge clk_i);
    ack_ovf_i = 1'b0; ack_ovf_hi_i = 1'b0;
  endtask

  // preload, start with internal clocking on at least one counter, and follow each tick
  task automatic run_steps(input string req, input logic [1:0] m, input bit ext,
                           input bit run_hi, input logic [7:0] l0, input logic [7:0] h0,
                           input int steps);
    logic [17:0] exp, prev;
    bit le, he, seen;
    le = !ext;
    he = run_hi && (m == 2'd3);
    bus_wr(2'd2, {3'b0, 1'b0, m, ext, 1'b0});
    bus_wr(2'd0, l0);
    bus_wr(2'd1, h0);
    ack_both();
    exp = {2'b00, h0, l0};
    check({req, " preload"}, obs(), exp);
    bus_wr(2'd2, {3'b0, run_hi, m, ext, 1'b1});
    seen = 1'b0;
    for (int i = 0; i < 14 && !seen; i++) begin
      if (obs() != exp) seen = 1'b1;
      else @(negedge clk_i);
    end
    prev = exp;
    exp = model(m, prev[15:8], prev[7:0], le, he);
    exp[17:16] = exp[17:16] | prev[17:16];
    check({req, " first tick"}, obs(), exp);
    for (int s = 1; s < steps; s++) begin
      repeat (11) @(negedge clk_i);
      check({req, " R1 stable between ticks"}, obs(), exp);
      @(negedge clk_i);
      prev = exp;
      exp = model(m, prev[15:8], prev[7:0], le, he);
      exp[17:16] = exp[17:16] | prev[17:16];
      check({req, " step"}, obs(), exp);
    end
  endtask

  initial begin
    logic [17:0] snap;
    repeat (3) @(negedge clk_i);
    check("R10 reset state", obs(), 18'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R10 after release", obs(), 18'h0);

    run_steps("R5 mode1 wrap", 2'd1, 1'b0, 1'b0, 8'hF0, 8'hFF, 20);
    check("R8 flag sticky", {17'b0, ovf_o}, 18'd1);
    @(negedge clk_i); ack_ovf_i = 1'b1;
    @(negedge clk_i); ack_ovf_i = 1'b0;
    check("R8 ack clears", {17'b0, ovf_o}, 18'd0);

    run_steps("R5 mode1 mid", 2'd1, 1'b0, 1'b0, 8'hFE, 8'h12, 5);
    run_steps("R4 mode0 wrap", 2'd0, 1'b0, 1'b0, 8'hE0, 8'hFF, 36);
    run_steps("R4 mode0 carry", 2'd0, 1'b0, 1'b0, 8'h5D, 8'h40, 6);
    run_steps("R6 mode2 reload", 2'd2, 1'b0, 1'b0, 8'hFD, 8'hFC, 10);
    run_steps("R6 mode2 reload zero", 2'd2, 1'b0, 1'b0, 8'hFF, 8'h00, 4);
    run_steps("R7 mode3 split", 2'd3, 1'b0, 1'b1, 8'hFB, 8'hFE, 8);
    run_steps("R7 mode3 hi stopped", 2'd3, 1'b0, 1'b0, 8'hFE, 8'h77, 4);
    run_steps("R7 R2 mode3 hi internal, ext pin steady", 2'd3, 1'b1, 1'b1, 8'h33, 8'hFD, 5);

    // R3: stop and hold, writes still apply
    bus_wr(2'd2, 8'h04);
    snap = obs();
    repeat (50) @(negedge clk_i);
    check("R3 hold when stopped", obs(), snap);
    bus_wr(2'd0, 8'hA5);
    check("R3 R9 write while stopped", {2'b00, cnt_hi_o, cnt_lo_o}, {2'b00, snap[15:8], 8'hA5});

    // R2: external falls in mode 1
    ack_both();
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd2, 8'h07);
    repeat (40) @(negedge clk_i);
    check("R2 steady pin no count", obs(), 18'h0);
    for (int p = 1; p <= 6; p++) begin
      ext_pin_i = 1'b1;
      repeat (40) @(negedge clk_i);
      check("R2 rising pin no count", obs(), {2'b00, 16'(p - 1)});
      ext_pin_i = 1'b0;
      repeat (40) @(negedge clk_i);
      check("R2 one count per fall", obs(), {2'b00, 16'(p)});
    end

    // R9: write overrides a running count
    bus_wr(2'd2, 8'h05);
    repeat (5) @(negedge clk_i);
    bus_wr(2'd1, 8'h3C);
    check("R9 hi write while running", {10'b0, cnt_hi_o}, {10'b0, 8'h3C});
    bus_wr(2'd3, 8'h99);
    check("R9 unused select ignored", {10'b0, cnt_hi_o}, {10'b0, 8'h3C});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule